// File: doc/BRIEF.md
# Outbound Address Translation Window Table

This block maps outbound addresses issued by the CPU side onto PCIe bus addresses. It holds eight programmable windows. Each window has a 64-bit source base, an enable flag, a power-of-two span code, a 64-bit translated base and a parameter word. The parameter word carries a resource-type code and a TLP-type code.

Every lookup request returns one of two results one cycle later. On a hit, the block returns the translated address, the TLP type and the index of the window that matched. On a miss, it raises an error flag.

A simple register port programs the table and reads it back. Software fills the windows once, during bring-up, before it sends traffic. Building the packets and config-space access belong to other blocks.

Top module: `obx_table`

## Requirements
- R1: While rst_n is low at a clock edge, and on the first edge after that, all response outputs and rd_data are zero. After reset every table word reads zero and every lookup misses.
- R2: Window n occupies register bytes 0x800+0x20*n. Its words sit at these offsets: +0x0 source-low, +0x4 source-high, +0x8 translated-low, +0xC translated-high, +0x10 parameters. A word written there reads back unchanged in rd_data on the cycle after rd_en.
- R3: A write is ignored in each of these cases: the address lies below 0x800 or at/above 0x900 (window index 8 or more), the address is not word aligned, or the address is one of the unused offsets +0x14..+0x1C. A read of any such address returns zero.
- R4: Bit 0 of source-low enables the window. A disabled window never hits.
- R5: Bits 6:1 of source-low hold a code c, and the window spans 2^(c+1) bytes. With L = c+1, a request hits when address bits [63:L] equal the base bits [63:L]. The base is {source-high, source-low[31:7], seven zero bits}.
- R6: On a hit, rsp_addr takes bits [63:L] from the translated base and bits [L-1:0] from the request.
- R7: rsp_tlp carries bits 18:16 of the hitting window's parameter word (0 memory, 2 I/O). Bits 3:0 (0 memory, 1 I/O) are stored and read back.
- R8: When several windows hit, the lowest-numbered one wins, and rsp_win reports its index.
- R9: On a miss, rsp_err is 1 and rsp_hit is 0, and rsp_addr, rsp_tlp and rsp_win are zero.
- R10: The response for a request in cycle t is presented in cycle t+1, and responses can follow back to back. With no request, rsp_valid, rsp_hit and rsp_err are 0 and the data outputs are zero.
- R11: Code 63 gives a 2^64 span. That window matches every address, and the request passes through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 12 | Register byte address |
| wr_data | input | 32 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 12 | Register read byte address |
| rd_data | output | 32 | Read data, one cycle after rd_en |
| req_valid | input | 1 | Lookup request valid |
| req_addr | input | 64 | Outbound address to translate |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_hit | output | 1 | A window matched |
| rsp_err | output | 1 | No window matched |
| rsp_addr | output | 64 | Translated address |
| rsp_tlp | output | 3 | TLP type of the hitting window |
| rsp_win | output | 3 | Index of the hitting window |

## Verification
Each lookup result and each read result is due exactly one clock edge after its strobe. A write changes the table for lookups from the next edge onward. The bench model keeps its own copy of the table. At every rising edge it computes the expected response from the inputs sampled at that edge, then applies any write. It compares all outputs one time unit after the edge, so every cycle is checked at its own due time, including idle and reset cycles.

// File: rtl/obx_pkg.sv
// Shared field positions and the per-window configuration record.
// Assumes 32-bit register words and five live words per window.
package obx_pkg;
    localparam int WORD_W    = 32;
    localparam int WORDS     = 5;
    localparam int EN_BIT    = 0;
    localparam int SZ_LSB    = 1;
    localparam int SZ_MSB    = 6;
    localparam int BASE_LSB  = 7;
    localparam int TLP_LSB   = 16;
    localparam int TLP_MSB   = 18;
    localparam int TLP_W     = TLP_MSB - TLP_LSB + 1;

    typedef struct packed {
        logic [WORD_W-1:0] src_lo;
        logic [WORD_W-1:0] src_hi;
        logic [WORD_W-1:0] dst_lo;
        logic [WORD_W-1:0] dst_hi;
        logic [WORD_W-1:0] param;
    } win_cfg_t;
endpackage

// File: rtl/obx_regfile.sv
// Register file holding the window table, with one write port and one
// registered read port. Assumes a power-of-two window stride that is at
// least 32 bytes. Unmapped addresses are dropped on write and read as zero.
module obx_regfile
    import obx_pkg::*;
#(
    parameter int NUM_WIN    = 8,
    parameter int REG_AW     = 12,
    parameter int TABLE_BASE = 'h800,
    parameter int STRIDE_LG  = 5
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [REG_AW-1:0]               wr_addr,
    input  logic [WORD_W-1:0]               wr_data,
    input  logic                            rd_en,
    input  logic [REG_AW-1:0]               rd_addr,
    output logic [WORD_W-1:0]               rd_data,
    output win_cfg_t [NUM_WIN-1:0]          cfg
);
    localparam int IDX_W = $clog2(NUM_WIN);
    localparam int SPAN  = NUM_WIN << STRIDE_LG;

    typedef struct packed {
        logic             ok;
        logic [IDX_W-1:0] idx;
        logic [2:0]       word;
    } dec_t;

    // Split a byte address into window index and word, flagging holes.
    function automatic dec_t decode(input logic [REG_AW-1:0] a);
        logic [REG_AW-1:0] off;
        dec_t d;
        off    = a - REG_AW'(TABLE_BASE);
        d.ok   = (a >= REG_AW'(TABLE_BASE)) && (off < REG_AW'(SPAN)) &&
                 (off[1:0] == 2'b00) &&
                 (int'(off[STRIDE_LG-1:2]) < WORDS);
        d.idx  = off[IDX_W+STRIDE_LG-1:STRIDE_LG];
        d.word = 3'(off[STRIDE_LG-1:2]);
        return d;
    endfunction

    dec_t wdec, rdec;

    // Decode both register ports.
    always_comb begin
        wdec = decode(wr_addr);
        rdec = decode(rd_addr);
    end

    generate
        for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
            // Store writes aimed at this window.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cfg[w] <= '0;
                end else if (wr_en && wdec.ok && wdec.idx == IDX_W'(w)) begin
                    case (wdec.word)
                        3'd0:    cfg[w].src_lo <= wr_data;
                        3'd1:    cfg[w].src_hi <= wr_data;
                        3'd2:    cfg[w].dst_lo <= wr_data;
                        3'd3:    cfg[w].dst_hi <= wr_data;
                        default: cfg[w].param  <= wr_data;
                    endcase
                end
            end
        end
    endgenerate

    // Return the addressed word one cycle after the read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || !rd_en || !rdec.ok) begin
            rd_data <= '0;
        end else begin
            case (rdec.word)
                3'd0:    rd_data <= cfg[rdec.idx].src_lo;
                3'd1:    rd_data <= cfg[rdec.idx].src_hi;
                3'd2:    rd_data <= cfg[rdec.idx].dst_lo;
                3'd3:    rd_data <= cfg[rdec.idx].dst_hi;
                default: rd_data <= cfg[rdec.idx].param;
            endcase
        end
    end
endmodule

// File: rtl/obx_match.sv
// Compares one request address against every window in parallel and
// produces each window's hit flag, translated address and TLP type.
// Assumes AW <= 64. The low BASE_LSB bits of the source base read as zero.
module obx_match
    import obx_pkg::*;
#(
    parameter int NUM_WIN = 8,
    parameter int AW      = 64
) (
    input  win_cfg_t [NUM_WIN-1:0]          cfg,
    input  logic [AW-1:0]                   req_addr,
    output logic [NUM_WIN-1:0]              hit_vec,
    output logic [NUM_WIN-1:0][AW-1:0]      xlat,
    output logic [NUM_WIN-1:0][TLP_W-1:0]   tlp
);
    localparam int LG_W = 7;

    generate
        for (genvar w = 0; w < NUM_WIN; w++) begin : g_cmp
            logic [LG_W-1:0]       lg;
            logic [AW-1:0]         mask;
            logic [2*WORD_W-1:0]   base_full;
            logic [2*WORD_W-1:0]   dst_full;

            // Derive span mask, compare base and splice the translated address.
            always_comb begin
                lg        = LG_W'(cfg[w].src_lo[SZ_MSB:SZ_LSB]) + LG_W'(1);
                mask      = (int'(lg) >= AW) ? '0 : ({AW{1'b1}} << lg);
                base_full = {cfg[w].src_hi, cfg[w].src_lo[WORD_W-1:BASE_LSB],
                             {BASE_LSB{1'b0}}};
                dst_full  = {cfg[w].dst_hi, cfg[w].dst_lo};
                hit_vec[w] = cfg[w].src_lo[EN_BIT] &&
                             ((req_addr & mask) == (base_full[AW-1:0] & mask));
                xlat[w]   = (dst_full[AW-1:0] & mask) | (req_addr & ~mask);
                tlp[w]    = cfg[w].param[TLP_MSB:TLP_LSB];
            end
        end
    endgenerate
endmodule

// File: rtl/obx_pick.sv
// Fixed-priority selector: the lowest-numbered hitting window wins.
module obx_pick #(
    parameter int NUM_WIN = 8,
    parameter int AW      = 64,
    parameter int TW      = 3
) (
    input  logic [NUM_WIN-1:0]              hit_vec,
    input  logic [NUM_WIN-1:0][AW-1:0]      xlat,
    input  logic [NUM_WIN-1:0][TW-1:0]      tlp,
    output logic                            any,
    output logic [$clog2(NUM_WIN)-1:0]      idx,
    output logic [AW-1:0]                   addr,
    output logic [TW-1:0]                   type_o
);
    localparam int IDX_W = $clog2(NUM_WIN);

    // Scan from the top so the lowest hit is the last assignment.
    always_comb begin
        any    = 1'b0;
        idx    = '0;
        addr   = '0;
        type_o = '0;
        for (int w = NUM_WIN - 1; w >= 0; w--) begin
            if (hit_vec[w]) begin
                any    = 1'b1;
                idx    = IDX_W'(w);
                addr   = xlat[w];
                type_o = tlp[w];
            end
        end
    end
endmodule

// File: rtl/obx_table.sv
// Top of the outbound translation table: register file, parallel window
// compare, priority pick and one output register stage. A lookup uses
// the table contents held at the edge that samples the request.
module obx_table
    import obx_pkg::*;
#(
    parameter int NUM_WIN    = 8,
    parameter int AW         = 64,
    parameter int REG_AW     = 12,
    parameter int TABLE_BASE = 'h800,
    parameter int STRIDE_LG  = 5
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [REG_AW-1:0]           wr_addr,
    input  logic [31:0]                 wr_data,
    input  logic                        rd_en,
    input  logic [REG_AW-1:0]           rd_addr,
    output logic [31:0]                 rd_data,
    input  logic                        req_valid,
    input  logic [AW-1:0]               req_addr,
    output logic                        rsp_valid,
    output logic                        rsp_hit,
    output logic                        rsp_err,
    output logic [AW-1:0]               rsp_addr,
    output logic [2:0]                  rsp_tlp,
    output logic [$clog2(NUM_WIN)-1:0]  rsp_win
);
    localparam int IDX_W = $clog2(NUM_WIN);

    win_cfg_t [NUM_WIN-1:0]            cfg;
    logic [NUM_WIN-1:0]                hit_vec;
    logic [NUM_WIN-1:0][AW-1:0]        xlat;
    logic [NUM_WIN-1:0][TLP_W-1:0]     tlp;
    logic                              any;
    logic [IDX_W-1:0]                  sel_idx;
    logic [AW-1:0]                     sel_addr;
    logic [TLP_W-1:0]                  sel_tlp;

    obx_regfile #(
        .NUM_WIN(NUM_WIN), .REG_AW(REG_AW),
        .TABLE_BASE(TABLE_BASE), .STRIDE_LG(STRIDE_LG)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .cfg(cfg)
    );

    obx_match #(.NUM_WIN(NUM_WIN), .AW(AW)) u_match (
        .cfg(cfg), .req_addr(req_addr),
        .hit_vec(hit_vec), .xlat(xlat), .tlp(tlp)
    );

    obx_pick #(.NUM_WIN(NUM_WIN), .AW(AW), .TW(TLP_W)) u_pick (
        .hit_vec(hit_vec), .xlat(xlat), .tlp(tlp),
        .any(any), .idx(sel_idx), .addr(sel_addr), .type_o(sel_tlp)
    );

    // Register the lookup result; outputs are zero when no request.
    always_ff @(posedge clk) begin
        if (!rst_n || !req_valid) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_addr  <= '0;
            rsp_tlp   <= '0;
            rsp_win   <= '0;
        end else begin
            rsp_valid <= 1'b1;
            rsp_hit   <= any;
            rsp_err   <= !any;
            rsp_addr  <= any ? sel_addr : '0;
            rsp_tlp   <= any ? sel_tlp  : '0;
            rsp_win   <= any ? sel_idx  : '0;
        end
    end
endmodule

// File: rtl/obx_checker.sv
// Protocol checks on the translation table's ports, attached by bind.
module obx_checker #(
    parameter int NUM_WIN    = 8,
    parameter int AW         = 64,
    parameter int REG_AW     = 12,
    parameter int TABLE_BASE = 'h800,
    parameter int STRIDE_LG  = 5
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        rd_en,
    input logic [REG_AW-1:0]           rd_addr,
    input logic [31:0]                 rd_data,
    input logic                        req_valid,
    input logic                        rsp_valid,
    input logic                        rsp_hit,
    input logic                        rsp_err,
    input logic [AW-1:0]               rsp_addr,
    input logic [2:0]                  rsp_tlp,
    input logic [$clog2(NUM_WIN)-1:0]  rsp_win
);
    localparam int TOP = TABLE_BASE + (NUM_WIN << STRIDE_LG);

    assert_rsp_follows_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && !rsp_hit && !rsp_err && rsp_addr == '0));

    assert_hit_or_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_hit != rsp_err));

    assert_miss_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_addr == '0 && rsp_tlp == '0 && rsp_win == '0));

    assert_rd_hole_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && int'(rd_addr) >= TOP) |=> rd_data == '0);
endmodule

bind obx_table obx_checker #(
    .NUM_WIN(NUM_WIN), .AW(AW), .REG_AW(REG_AW),
    .TABLE_BASE(TABLE_BASE), .STRIDE_LG(STRIDE_LG)
) u_chk (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .req_valid(req_valid), .rsp_valid(rsp_valid),
    .rsp_hit(rsp_hit), .rsp_err(rsp_err), .rsp_addr(rsp_addr),
    .rsp_tlp(rsp_tlp), .rsp_win(rsp_win)
);

// File: tb/obx_table_test.sv
module obx_table_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        wr_en = 0;
    logic [11:0] wr_addr = 0;
    logic [31:0] wr_data = 0;
    logic        rd_en = 0;
    logic [11:0] rd_addr = 0;
    logic [31:0] rd_data;
    logic        req_valid = 0;
    logic [63:0] req_addr = 0;
    logic        rsp_valid, rsp_hit, rsp_err;
    logic [63:0] rsp_addr;
    logic [2:0]  rsp_tlp, rsp_win;

    int    checks = 0;
    int    errors = 0;
    string tag = "R1";

    logic [31:0] mreg [8][5];

    obx_table uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .req_valid(req_valid), .req_addr(req_addr), .rsp_valid(rsp_valid),
        .rsp_hit(rsp_hit), .rsp_err(rsp_err), .rsp_addr(rsp_addr),
        .rsp_tlp(rsp_tlp), .rsp_win(rsp_win)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic bit map_ok(input int a, output int w, output int k);
        int off;
        off = a - 'h800;
        w = off / 32;
        k = (off % 32) / 4;
        return (a >= 'h800) && (a < 'h900) && (a % 4 == 0) && (k < 5);
    endfunction

    function automatic logic [31:0] m_read(input int a);
        int w, k;
        if (map_ok(a, w, k)) return mreg[w][k];
        return 0;
    endfunction

    task automatic m_lookup(input logic [63:0] a, output logic h,
                            output logic [63:0] o, output logic [2:0] t,
                            output logic [2:0] wi);
        h = 0; o = 0; t = 0; wi = 0;
        for (int w = 0; w < 8; w++) begin
            int L;
            logic [63:0] m, b;
            if (mreg[w][0][0] !== 1'b1) continue;
            L = int'(mreg[w][0][6:1]) + 1;
            m = (L >= 64) ? 64'd0 : (~64'd0 << L);
            b = {mreg[w][1], mreg[w][0][31:7], 7'd0};
            if ((a & m) == (b & m)) begin
                h = 1;
                o = ({mreg[w][3], mreg[w][2]} & m) | (a & ~m);
                t = mreg[w][4][18:16];
                wi = 3'(w);
                return;
            end
        end
    endtask

    task automatic check(input bit ok, input string what, input string act, input string exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%s expected=%s", tag, what, act, exp);
        end
    endtask

    // One clock: predict at the edge, update model, compare 1 unit later.
    task automatic tick();
        logic eh, ee, ev;
        logic [63:0] ea;
        logic [2:0] et, ew;
        logic [31:0] erd;
        int w, k;
        @(posedge clk);
        eh = 0; ee = 0; ev = 0; ea = 0; et = 0; ew = 0; erd = 0;
        if (!rst_n) begin
            foreach (mreg[i, j]) mreg[i][j] = 0;
        end else begin
            if (req_valid) begin
                ev = 1;
                m_lookup(req_addr, eh, ea, et, ew);
                ee = !eh;
            end
            if (rd_en) erd = m_read(int'(rd_addr));
            if (wr_en && map_ok(int'(wr_addr), w, k)) mreg[w][k] = wr_data;
        end
        #1;
        check({rsp_valid, rsp_hit, rsp_err, rsp_addr, rsp_tlp, rsp_win} ===
              {ev, eh, ee, ea, et, ew}, "response",
              $sformatf("v%0b h%0b e%0b a%h t%0d w%0d", rsp_valid, rsp_hit, rsp_err, rsp_addr, rsp_tlp, rsp_win),
              $sformatf("v%0b h%0b e%0b a%h t%0d w%0d", ev, eh, ee, ea, et, ew));
        check(rd_data === erd, "rd_data", $sformatf("%h", rd_data), $sformatf("%h", erd));
    endtask

    task automatic idle();
        wr_en = 0; rd_en = 0; req_valid = 0;
        tick();
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        wr_en = 1; wr_addr = 12'(a); wr_data = d; rd_en = 0; req_valid = 0;
        tick();
        wr_en = 0;
    endtask

    task automatic rd(input int a);
        rd_en = 1; rd_addr = 12'(a); wr_en = 0; req_valid = 0;
        tick();
        rd_en = 0;
    endtask

    task automatic look(input logic [63:0] a);
        req_valid = 1; req_addr = a; wr_en = 0; rd_en = 0;
        tick();
        req_valid = 0;
    endtask

    task automatic prog(input int w, input logic [31:0] slo, input logic [31:0] shi,
                        input logic [31:0] dlo, input logic [31:0] dhi, input logic [31:0] p);
        wr('h800 + 32*w + 0,  slo);
        wr('h800 + 32*w + 4,  shi);
        wr('h800 + 32*w + 8,  dlo);
        wr('h800 + 32*w + 12, dhi);
        wr('h800 + 32*w + 16, p);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R10 watchdog actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state, even with a request and a read pending
        tag = "R1";
        rst_n = 0; req_valid = 1; req_addr = 64'h1234; rd_en = 1; rd_addr = 12'h800;
        repeat (3) tick();
        rst_n = 1; req_valid = 0; rd_en = 0;
        tick();
        rd('h800); rd('h810); look(64'h0); look(64'h1_2000_0000); idle();

        // R2: programming and read-back
        tag = "R2";
        prog(0, 32'h2000_0027, 32'h1, 32'h8000_0000, 32'h0, 32'h0);          // 1 MiB memory
        prog(1, 32'h3000_001F, 32'h0, 32'h0001_0000, 32'h0, 32'h0002_0001);  // 64 KiB I/O
        for (int k = 0; k < 5; k++) rd('h820 + 4*k);
        rd('h800); rd('h804); idle();

        // R3: out-of-range index, holes, misaligned, below base
        tag = "R3";
        wr('h900, 32'hFFFF_FFFF); wr('h920, 32'hFFFF_FFFF); wr('h814, 32'hDEAD_BEEF);
        wr('h802, 32'hDEAD_BEEF); wr('h7FC, 32'hDEAD_BEEF); wr('h81C, 32'h1234_5678);
        rd('h900); rd('h814); rd('h81C); rd('h7FC); rd('h800); rd('h810);
        look(64'h0000_0000_0000_0000); idle();

        // R5 / R6: hits and boundaries of 1 MiB window 0
        tag = "R5";
        look(64'h1_2000_0000); look(64'h1_200F_FFFF); look(64'h1_2010_0000);
        look(64'h0_2000_0000); look(64'h1_1FFF_FFFF);
        tag = "R6";
        look(64'h1_2003_4567); look(64'h0_3000_ABCD);
        // R7: I/O TLP type reported from window 1
        tag = "R7";
        look(64'h0_3000_FFFF); look(64'h0_3001_0000); rd('h830); idle();

        // Small window below 128 bytes: span 16 bytes at 0x1000
        tag = "R5";
        prog(4, 32'h0000_1007, 32'h0, 32'hABC0_0000, 32'h0, 32'h0);
        look(64'h1000); look(64'h100F); look(64'h1010); look(64'h0FFF); idle();

        // R8: overlapping 1 GiB window 2 loses to window 0
        tag = "R8";
        prog(2, 32'h0000_003B, 32'h1, 32'h0, 32'h40, 32'h0);
        look(64'h1_2000_1234); look(64'h1_0500_0000); look(64'h1_3FFF_FFFF);

        // R4: disabled window never hits, then enable it
        tag = "R4";
        prog(3, 32'h5000_0016, 32'h0, 32'h7000_0000, 32'h0, 32'h0002_0001);
        wr('h860, 32'h5000_0016 & ~32'h1);
        look(64'h5000_0010); look(64'h5000_0FFF);
        wr('h860, 32'h5000_0017);
        look(64'h5000_0010); look(64'h5000_0FFF); look(64'h5000_1000);

        // R9: misses
        tag = "R9";
        look(64'hFFFF_0000_0000_0000); look(64'h9000_0000); idle();

        // R10: back-to-back requests and an immediate idle
        tag = "R10";
        look(64'h1_2000_0001); look(64'hFFFF_0000_0000_0000); look(64'h1000);
        look(64'h0_3000_0002); idle(); idle();

        // R11: catch-all window 7 with code 63
        tag = "R11";
        prog(7, 32'h0000_007F, 32'h0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0002_0001);
        look(64'hFFFF_0000_0000_0000); look(64'h9000_0000); look(64'h1_2000_0000);
        look(64'h0); idle();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule